// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects level-sensitive interrupt sources and presents three request lines to a processor: a normal interrupt line, a fast interrupt line and an endpoint line. The sources come in banks of 32. Each bank has its own register set. The set holds a read-only view of the raw source levels and three enable masks. Each mask selects which of those levels may drive one of the three output lines.

Software reaches the registers over a plain single-cycle read/write bus. Each bank takes a 16-byte window, and bank `b` starts at byte address `0x10*b`. The block keeps no history of the sources. A source that drops its level also drops its contribution to every output. Software finds the requester by reading the cause words and ANDing them with its copy of the masks.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask register of every bank reads 0, and `irq_out`, `fiq_out` and `ep_out` are 0 whatever the source levels are.
- R2: A read at register offset 0x0 of bank `b` returns the current levels `src_lvl[32*b+31 : 32*b]`, with bit `i` of the word equal to source `32*b+i`.
- R3: A write to offset 0x0 has no effect: no mask changes, no output changes, and the next read of offset 0x0 still returns the source levels.
- R4: The normal-interrupt mask is at offset 0x4. A written word is read back unchanged, and a bit set to 1 enables the matching source.
- R5: `irq_out` is the OR, over all banks, of the source levels ANDed with the normal mask. It is registered, so it changes on the first rising clock edge after a source or mask change and not before.
- R6: The fast-interrupt mask is at offset 0x8, and `fiq_out` is the OR of the source levels ANDed with this mask, registered the same way as `irq_out`.
- R7: The endpoint mask is at offset 0xC, and `ep_out` is the OR of the source levels ANDed with this mask, registered the same way as `irq_out`.
- R8: The bank is picked by address bits 4 and up. A write to one bank leaves the registers of every other bank unchanged, and a source in bank 1 reaches the outputs only through bank 1's masks.
- R9: Writing 0 to a mask register disables every source of that bank on the matching output.
- R10: The three masks act independently on the same source levels. A source enabled in only one mask asserts only the matching output.
- R11: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value in every other cycle, even when the source levels change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data valid the cycle after |
| bus_addr | input | ADDR_W (5) | Byte address: bits 3:2 register, bits 4 and up bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | 32*NUM_BANKS (64) | Level-sensitive source inputs |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| ep_out | output | 1 | Endpoint request |

## Verification
The bench drives the sources in three ways: all sources high with every mask clear, a single source under a single enabled mask, and sources in the other bank only. The first pattern separates a real mask from one that lets everything through. The second pattern shows which of the three outputs is wired to which mask, and whether the output is registered. The third pattern shows whether the bank decode routes both writes and levels to the right bank. Cause-register writes and idle read cycles with changing levels check that neither of them disturbs any state the bench can observe.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam int BANK_SRCS = 32;

  // register selector taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_IRQ   = 2'd1,
    SEL_FIQ   = 2'd2,
    SEL_EP    = 2'd3
  } reg_sel_e;

  // true when any enabled source is active
  function automatic logic gate_any(input logic [BANK_SRCS-1:0] lvl,
                                    input logic [BANK_SRCS-1:0] en);
    return |(lvl & en);
  endfunction

endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
  import lvl_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [BANK_SRCS-1:0] wr_data,
  input  logic [1:0]           rd_sel,
  input  logic [BANK_SRCS-1:0] lvl,
  output logic [BANK_SRCS-1:0] rd_val,
  output logic [BANK_SRCS-1:0] irq_en,
  output logic [BANK_SRCS-1:0] fiq_en,
  output logic [BANK_SRCS-1:0] ep_en,
  output logic                 irq_hit,
  output logic                 fiq_hit,
  output logic                 ep_hit
);

  localparam int NUM_MASKS = 3;

  logic [NUM_MASKS-1:0][BANK_SRCS-1:0] mask_q;

  // one register per mask; selector k+1 addresses mask k, selector 0 is read-only
  for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[k] <= '0;
      end else if (wr_en && (wr_sel == 2'(k + 1))) begin
        mask_q[k] <= wr_data;
      end
    end
  end

  assign irq_en = mask_q[0];
  assign fiq_en = mask_q[1];
  assign ep_en  = mask_q[2];

  assign irq_hit = gate_any(lvl, irq_en);
  assign fiq_hit = gate_any(lvl, fiq_en);
  assign ep_hit  = gate_any(lvl, ep_en);

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CAUSE: rd_val = lvl;
      SEL_IRQ:   rd_val = irq_en;
      SEL_FIQ:   rd_val = fiq_en;
      SEL_EP:    rd_val = ep_en;
      default:   rd_val = '0;
    endcase
  end

endmodule

// File: rtl/lvl_intc_outreg.sv
module lvl_intc_outreg #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] irq_hits,
  input  logic [NUM_BANKS-1:0] fiq_hits,
  input  logic [NUM_BANKS-1:0] ep_hits,
  output logic                 irq_q,
  output logic                 fiq_q,
  output logic                 ep_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      ep_q  <= 1'b0;
    end else begin
      irq_q <= |irq_hits;
      fiq_q <= |fiq_hits;
      ep_q  <= |ep_hits;
    end
  end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + 4,
  localparam int SRC_W    = NUM_BANKS * BANK_SRCS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BANK_SRCS-1:0] bus_wdata,
  output logic [BANK_SRCS-1:0] bus_rdata,
  input  logic [SRC_W-1:0]     src_lvl,
  output logic                 irq_out,
  output logic                 fiq_out,
  output logic                 ep_out
);

  logic [BANK_W-1:0] bank_sel;
  logic [1:0]        reg_sel;
  logic              bank_ok;

  assign bank_sel = bus_addr[ADDR_W-1:4];
  assign reg_sel  = bus_addr[3:2];
  assign bank_ok  = (32'(bank_sel) < NUM_BANKS);

  // named internal state for the checker
  logic [SRC_W-1:0]                     irq_mask_all;
  logic [SRC_W-1:0]                     fiq_mask_all;
  logic [SRC_W-1:0]                     ep_mask_all;
  logic [NUM_BANKS-1:0][BANK_SRCS-1:0]  bank_rd;
  logic [NUM_BANKS-1:0]                 irq_hits, fiq_hits, ep_hits;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_this;
    assign wr_this = bus_wr && bank_ok && (32'(bank_sel) == b);

    lvl_intc_bank u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_this),
      .wr_sel  (reg_sel),
      .wr_data (bus_wdata),
      .rd_sel  (reg_sel),
      .lvl     (src_lvl[b*BANK_SRCS +: BANK_SRCS]),
      .rd_val  (bank_rd[b]),
      .irq_en  (irq_mask_all[b*BANK_SRCS +: BANK_SRCS]),
      .fiq_en  (fiq_mask_all[b*BANK_SRCS +: BANK_SRCS]),
      .ep_en   (ep_mask_all[b*BANK_SRCS +: BANK_SRCS]),
      .irq_hit (irq_hits[b]),
      .fiq_hit (fiq_hits[b]),
      .ep_hit  (ep_hits[b])
    );
  end

  logic [BANK_SRCS-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_ok && (32'(bank_sel) == b)) rd_word = bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end

  lvl_intc_outreg #(.NUM_BANKS(NUM_BANKS)) u_outreg (
    .clk      (clk),
    .rst      (rst),
    .irq_hits (irq_hits),
    .fiq_hits (fiq_hits),
    .ep_hits  (ep_hits),
    .irq_q    (irq_out),
    .fiq_q    (fiq_out),
    .ep_q     (ep_out)
  );

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 5,
  parameter int SRC_W     = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [SRC_W-1:0]  src_lvl,
  input logic              irq_out,
  input logic              fiq_out,
  input logic              ep_out,
  input logic [SRC_W-1:0]  irq_mask_all,
  input logic [SRC_W-1:0]  fiq_mask_all,
  input logic [SRC_W-1:0]  ep_mask_all
);

  logic wr_cause, wr_irq0;
  assign wr_cause = bus_wr && (bus_addr[3:2] == 2'd0);
  assign wr_irq0  = bus_wr && (bus_addr[3:2] == 2'd1) && (bus_addr[ADDR_W-1:4] == '0);

  // R1: outputs idle in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && !fiq_out && !ep_out));

  // R3: cause writes leave all masks alone
  a_r3_cause_write_inert: assert property (@(posedge clk) disable iff (rst)
    wr_cause |=> ($stable(irq_mask_all) && $stable(fiq_mask_all) && $stable(ep_mask_all)));

  // R4: a write to bank 0 normal mask lands
  a_r4_irq_mask_lands: assert property (@(posedge clk) disable iff (rst)
    wr_irq0 |=> (irq_mask_all[31:0] == $past(bus_wdata)));

  // R5: normal line follows gated levels one cycle late
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(src_lvl & irq_mask_all))));

  // R6: fast line follows gated levels one cycle late
  a_r6_fiq_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fiq_out == $past(|(src_lvl & fiq_mask_all))));

  // R7: endpoint line follows gated levels one cycle late
  a_r7_ep_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ep_out == $past(|(src_lvl & ep_mask_all))));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind lvl_intc lvl_intc_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .SRC_W     (SRC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .src_lvl      (src_lvl),
  .irq_out      (irq_out),
  .fiq_out      (fiq_out),
  .ep_out       (ep_out),
  .irq_mask_all (irq_mask_all),
  .fiq_mask_all (fiq_mask_all),
  .ep_mask_all  (ep_mask_all)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;

  localparam int NB = 2;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [63:0]   src_lvl = '0;
  logic          irq_out, fiq_out, ep_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  lvl_intc #(.NUM_BANKS(NB)) i_lvl_intc (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .ep_out    (ep_out)
  );

  function automatic logic [AW-1:0] adr(input int bank, input int off);
    return AW'(bank * 16 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic i, input logic f, input logic e);
    chk(req, {29'd0, irq_out, fiq_out, ep_out}, {29'd0, i, f, e});
  endtask

  task automatic wr(input int bank, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = adr(bank, off); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int bank, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = adr(bank, off);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    src_lvl = '1;
    settle(); settle();
    chk_outs("R1 outputs after reset", 1'b0, 1'b0, 1'b0);
    for (int b = 0; b < NB; b++) begin
      for (int o = 4; o <= 12; o += 4) begin
        rd(b, o, v);
        chk("R1 mask reset", v, 32'h0);
      end
    end
    src_lvl = '0;
    settle();
  endtask

  task automatic t_cause_read();
    logic [31:0] v;
    src_lvl = 64'hA5A5_0F0F_1234_8001;
    rd(0, 0, v); chk("R2 cause bank0", v, 32'h1234_8001);
    rd(1, 0, v); chk("R2 cause bank1", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_cause_write();
    logic [31:0] v;
    src_lvl = 64'h0000_0003_0000_00F0;
    wr(0, 0, 32'hFFFF_FFFF);
    wr(1, 0, 32'hFFFF_FFFF);
    settle();
    chk_outs("R3 cause write no output", 1'b0, 1'b0, 1'b0);
    rd(0, 0, v); chk("R3 cause still levels", v, 32'h0000_00F0);
    rd(0, 4, v); chk("R3 irq mask untouched", v, 32'h0);
    rd(1, 8, v); chk("R3 fiq mask untouched", v, 32'h0);
    src_lvl = '0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(0, 4, 32'h0000_0100);
    rd(0, 4, v); chk("R4 irq mask readback", v, 32'h0000_0100);
    settle();
    chk_outs("R5 masked-off idle", 1'b0, 1'b0, 1'b0);
    @(negedge clk); src_lvl[8] = 1'b1;
    #2 chk_outs("R5 not before edge", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk_outs("R5 R10 irq only", 1'b1, 1'b0, 1'b0);
    src_lvl[8] = 1'b0;
    @(negedge clk);
    chk_outs("R5 level drop", 1'b0, 1'b0, 1'b0);
    src_lvl[9] = 1'b1;
    @(negedge clk);
    chk_outs("R5 unmasked neighbour", 1'b0, 1'b0, 1'b0);
    src_lvl = '0;
  endtask

  task automatic t_fiq_bank1();
    logic [31:0] v;
    wr(1, 8, 32'h8000_0000);
    rd(0, 8, v); chk("R8 bank0 fiq unchanged", v, 32'h0);
    rd(1, 8, v); chk("R6 fiq mask readback", v, 32'h8000_0000);
    @(negedge clk); src_lvl[31] = 1'b1;  // bank0 bit31: not enabled for fiq
    @(negedge clk);
    chk_outs("R8 bank0 source not via bank1 mask", 1'b0, 1'b0, 1'b0);
    src_lvl[63] = 1'b1;
    @(negedge clk);
    chk_outs("R6 R10 fiq only", 1'b0, 1'b1, 1'b0);
    src_lvl = '0;
    @(negedge clk);
    chk_outs("R6 fiq drop", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ep();
    logic [31:0] v;
    wr(1, 12, 32'h0000_0001);
    rd(1, 12, v); chk("R7 ep mask readback", v, 32'h0000_0001);
    @(negedge clk); src_lvl[32] = 1'b1;
    @(negedge clk);
    chk_outs("R7 R10 ep only", 1'b0, 1'b0, 1'b1);
    src_lvl = '0;
    settle();
  endtask

  task automatic t_clear();
    wr(0, 4, 32'hFFFF_FFFF);
    src_lvl = 64'h0000_0000_0000_0010;
    settle();
    chk_outs("R9 irq with full mask", 1'b1, 1'b0, 1'b0);
    wr(0, 4, 32'h0);
    settle();
    chk_outs("R9 irq after zero mask", 1'b0, 1'b0, 1'b0);
    src_lvl = '0;
  endtask

  task automatic t_rdata_hold();
    logic [31:0] v;
    src_lvl = 64'h0000_0000_0000_00AA;
    rd(0, 0, v); chk("R11 read value", v, 32'h0000_00AA);
    src_lvl = 64'h0000_0000_0000_0055;
    settle(); settle();
    chk("R11 rdata held", bus_rdata, 32'h0000_00AA);
    src_lvl = '0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cause_read();
    t_cause_write();
    t_irq();
    t_fiq_bank1();
    t_ep();
    t_clear();
    t_rdata_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule